// File: doc/BRIEF.md
# Serial Configuration Port for a Sampling Converter

This block is the configuration side of a converter-style serial slave. An active-low frame select, a serial clock and a serial data input arrive from the host. A strap selects chained operation. Inside a frame, the block looks for a command header. It writes or reads one 8-bit configuration byte, and it drives the serial data output with a separate output-enable pin that models a tristate pad. The four writable fields come out as control levels for the rest of the converter. An external overvoltage input feeds a sticky, active-low alarm bit that is kept in the same byte.

All serial inputs pass through a synchronizer into the core clock domain, and all serial edges are found in that domain. A frame is 16 serial bits: an 8-bit header and then 8 data bits. Leading ones before the header are skipped. A header with the wrong fixed code makes the block ignore the rest of the frame. A frame cut short by the frame select going high leaves the register untouched.

Top module: `adc_cfg_port`

## Requirements
- R1: After reset the configuration byte is 0xE1: all four field outputs are 0 and the alarm output `ovr_flag_n_o` is 1.
- R2: While `frame_n_i` is low, data bits sampled as 1 on rising serial clock edges are discarded. The first 0 sampled is header bit 7 and starts the header.
- R3: The header is sent MSB first as 0, then R/W (1 = read, 0 = write), then the fixed code 010100 in bits 5:0. A header whose code differs causes no write and no read output for the rest of the frame.
- R4: After a write header, 8 data bits follow MSB first. Bit 4 sets `status_en_o`, bit 3 sets `span_cmp_o`, bit 2 sets `hiz_mode_o` and bit 1 sets `turbo_o`. Written bits 7:5 and bit 0 have no effect. The update happens only after the eighth data bit, and writes are accepted in chained mode too.
- R5: If `frame_n_i` rises before the eighth data bit, the frame is dropped and the register keeps its value.
- R6: After a read header, the byte appears on `spi_dout_o` MSB first, one bit after each of the next 8 falling serial clock edges. Bits 7:5 read as 1, bits 4:1 are the fields and bit 0 is the alarm bit as it stood when the header completed.
- R7: While `frame_n_i` is low and no read data is being shifted out, including the whole header, `spi_dout_en_o` is 0.
- R8: While `frame_n_i` is high, `spi_dout_en_o` equals `chain_mode_i`, and `spi_dout_o` is 0 whenever it is enabled.
- R9: When `chain_mode_i` is 1, read headers are refused: `spi_dout_en_o` stays 0 for the frame and the alarm bit is not cleared.
- R10: A high level on `overvolt_i` drives `ovr_flag_n_o` to 0 within a few core clock cycles.
- R11: Once 0, the alarm bit stays 0 until a read frame completes all 8 data bits while `overvolt_i` is low. It then becomes 1. A read made while the input is still high leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_clk_i | input | 1 | Serial clock from the host |
| frame_n_i | input | 1 | Active-low frame select |
| spi_din_i | input | 1 | Serial data in, sampled on rising serial clock |
| chain_mode_i | input | 1 | Chained-operation strap |
| overvolt_i | input | 1 | Overvoltage indication, active high |
| spi_dout_o | output | 1 | Serial data out |
| spi_dout_en_o | output | 1 | Output enable for the serial data pad |
| status_en_o | output | 1 | Status-append enable field |
| span_cmp_o | output | 1 | Span compression field |
| hiz_mode_o | output | 1 | High-impedance mode field |
| turbo_o | output | 1 | Turbo mode field |
| ovr_flag_n_o | output | 1 | Sticky overvoltage alarm, 0 = alarm |

## Verification
The bench writes every one of the 256 data byte values and reads each one back. Each write is preceded by zero to three stray ones, so a design that treats a leading 1 as a header bit, maps a field to the wrong position, or lets the reserved bits or bit 0 be written fails on the first affected value. Corrupted header codes and frames cut off after four data bits are sent next. A decoder that ignores the code, or that commits data early, changes the fields there. The alarm is then raised, read while still active, released and read again, with chained mode toggled in between. This exposes a flag that clears without a read, clears while the input is still high, clears through a refused chained read, or reports the post-clear value in the same read.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

   // Frame parser states
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,   // frame open, waiting for the header's leading zero
      ST_HDR  = 2'd1,   // collecting the rest of the header
      ST_DATA = 2'd2,   // data byte phase (write in, or read out)
      ST_SKIP = 2'd3    // frame finished or rejected, wait for frame end
   } frame_st_t;

endpackage

// File: rtl/adc_cfg_sync.sv
module adc_cfg_sync #(
   parameter int           STAGES = 2,
   parameter int           W      = 1,
   parameter logic [W-1:0] INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{INIT}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/adc_cfg_frame.sv
module adc_cfg_frame
   import adc_cfg_pkg::*;
#(
   parameter int               HDR_W    = 8,
   parameter int               DATA_W   = 8,
   parameter int               CMD_W    = 6,
   parameter logic [CMD_W-1:0] CMD_CODE = 6'b010100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_act,
   input  logic              sck_rise,
   input  logic              din,
   input  logic              chain_en,
   output frame_st_t         st,
   output logic              reading,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_accept,
   output logic              rd_done
);

   localparam int MAX_W = (HDR_W > DATA_W) ? HDR_W : DATA_W;
   localparam int CNT_W = $clog2(MAX_W) + 1;

   logic [HDR_W-3:0]  hsh;
   logic [HDR_W-2:0]  hnext;
   logic [DATA_W-1:0] dsh;
   logic [DATA_W-1:0] dnext;
   logic [CNT_W-1:0]  cnt;
   logic              is_rd;
   logic              hdr_ok;
   logic              hdr_rd;

   assign hnext  = {hsh, din};
   assign dnext  = {dsh[DATA_W-2:0], din};
   assign hdr_ok = (hnext[CMD_W-1:0] == CMD_CODE);
   assign hdr_rd = hnext[HDR_W-2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_HUNT;
         cnt       <= '0;
         hsh       <= '0;
         dsh       <= '0;
         is_rd     <= 1'b0;
         wr_stb    <= 1'b0;
         rd_accept <= 1'b0;
         rd_done   <= 1'b0;
      end else begin
         wr_stb    <= 1'b0;
         rd_accept <= 1'b0;
         rd_done   <= 1'b0;
         if (!frame_act) begin
            st    <= ST_HUNT;
            cnt   <= '0;
            is_rd <= 1'b0;
         end else if (sck_rise) begin
            case (st)
               ST_HUNT: begin
                  if (!din) begin
                     st  <= ST_HDR;
                     cnt <= CNT_W'(1);
                     hsh <= '0;
                  end
               end
               ST_HDR: begin
                  hsh <= hnext[HDR_W-3:0];
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(HDR_W-1)) begin
                     cnt <= '0;
                     if (!hdr_ok || (hdr_rd && chain_en)) begin
                        st <= ST_SKIP;
                     end else begin
                        st        <= ST_DATA;
                        is_rd     <= hdr_rd;
                        rd_accept <= hdr_rd;
                     end
                  end
               end
               ST_DATA: begin
                  dsh <= dnext;
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(DATA_W-1)) begin
                     st      <= ST_SKIP;
                     wr_stb  <= ~is_rd;
                     rd_done <= is_rd;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign wr_data = dsh;
   assign reading = (st == ST_DATA) && is_rd;

endmodule

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = 8'hE1,
   parameter logic [DATA_W-1:0] RSV_MASK  = 8'hE0,
   parameter int                FLAG_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ovr,
   input  logic              rd_done,
   output logic [DATA_W-1:0] cfg_val
);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         if (i == FLAG_BIT) begin : g_flag
            logic flag_q;
            logic unused_wr_bit;
            assign unused_wr_bit = wr_data[i];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       flag_q <= RESET_VAL[i];
               else if (ovr)     flag_q <= 1'b0;
               else if (rd_done) flag_q <= 1'b1;
            end
            assign cfg_val[i] = flag_q;
         end else if (RSV_MASK[i]) begin : g_rsv
            logic unused_wr_bit;
            assign unused_wr_bit = wr_data[i];
            assign cfg_val[i]    = 1'b1;
         end else begin : g_rw
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      bit_q <= RESET_VAL[i];
               else if (wr_stb) bit_q <= wr_data[i];
            end
            assign cfg_val[i] = bit_q;
         end
      end
   endgenerate

endmodule

// File: rtl/adc_cfg_sdo.sv
module adc_cfg_sdo #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_act,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         sck_fall,
   input  logic         reading,
   input  logic         chain_en,
   output logic         dout,
   output logic         dout_en
);

   logic [W-1:0] sh;
   logic         q;
   logic         drv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         q   <= 1'b0;
         drv <= 1'b0;
      end else if (!frame_act) begin
         q   <= 1'b0;
         drv <= 1'b0;
      end else if (load) begin
         sh  <= load_val;
         drv <= 1'b0;
      end else if (!reading) begin
         drv <= 1'b0;
      end else if (sck_fall) begin
         q   <= sh[W-1];
         sh  <= {sh[W-2:0], 1'b0};
         drv <= 1'b1;
      end
   end

   // Between frames the pad is parked low in chained mode, released otherwise
   assign dout_en = frame_act ? drv : chain_en;
   assign dout    = frame_act ? q   : 1'b0;

endmodule

// File: rtl/adc_cfg_port.sv
module adc_cfg_port
   import adc_cfg_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                HDR_W       = 8,
   parameter int                DATA_W      = 8,
   parameter int                CMD_W       = 6,
   parameter logic [CMD_W-1:0]  CMD_CODE    = 6'b010100,
   parameter logic [DATA_W-1:0] RESET_VAL   = 8'hE1,
   parameter logic [DATA_W-1:0] RSV_MASK    = 8'hE0,
   parameter int                FLAG_BIT    = 0,
   parameter int                FIELD_STAT  = 4,
   parameter int                FIELD_SPAN  = 3,
   parameter int                FIELD_HIZ   = 2,
   parameter int                FIELD_TURBO = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_clk_i,
   input  logic frame_n_i,
   input  logic spi_din_i,
   input  logic chain_mode_i,
   input  logic overvolt_i,
   output logic spi_dout_o,
   output logic spi_dout_en_o,
   output logic status_en_o,
   output logic span_cmp_o,
   output logic hiz_mode_o,
   output logic turbo_o,
   output logic ovr_flag_n_o
);

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CMD_W != HDR_W - 2) begin : g_bad_hdr
      $error("CMD_W must equal HDR_W - 2");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (FLAG_BIT < 0 || FLAG_BIT >= DATA_W || RSV_MASK[FLAG_BIT]) begin : g_bad_flag
      $error("FLAG_BIT out of range or overlapping a reserved bit");
   end
   if (!RESET_VAL[FLAG_BIT] || ((RESET_VAL & RSV_MASK) != RSV_MASK)) begin : g_bad_reset
      $error("reset value must hold the alarm and reserved bits at 1");
   end
   if (FIELD_STAT >= DATA_W || FIELD_SPAN >= DATA_W ||
       FIELD_HIZ >= DATA_W || FIELD_TURBO >= DATA_W) begin : g_bad_field
      $error("field position outside the register");
   end

   localparam logic [3:0] SYNC_INIT = 4'b0110;   // overvolt, din, frame_n, clk

   logic [3:0]        raw_s;
   logic              sck_s;
   logic              frame_n_s;
   logic              din_s;
   logic              ovr_s;
   logic              sck_d;
   logic              sck_rise;
   logic              sck_fall;
   logic              frame_act;
   frame_st_t         st;
   logic              reading;
   logic              wr_stb;
   logic [DATA_W-1:0] wr_data;
   logic              rd_accept;
   logic              rd_done;
   logic [DATA_W-1:0] cfg_val;

   adc_cfg_sync #(
      .STAGES (SYNC_STAGES),
      .W      (4),
      .INIT   (SYNC_INIT)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({overvolt_i, spi_din_i, frame_n_i, spi_clk_i}),
      .q     (raw_s)
   );

   assign {ovr_s, din_s, frame_n_s, sck_s} = raw_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign sck_rise  =  sck_s & ~sck_d;
   assign sck_fall  = ~sck_s &  sck_d;
   assign frame_act = ~frame_n_s;

   adc_cfg_frame #(
      .HDR_W    (HDR_W),
      .DATA_W   (DATA_W),
      .CMD_W    (CMD_W),
      .CMD_CODE (CMD_CODE)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_act (frame_act),
      .sck_rise  (sck_rise),
      .din       (din_s),
      .chain_en  (chain_mode_i),
      .st        (st),
      .reading   (reading),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .rd_accept (rd_accept),
      .rd_done   (rd_done)
   );

   adc_cfg_regs #(
      .DATA_W    (DATA_W),
      .RESET_VAL (RESET_VAL),
      .RSV_MASK  (RSV_MASK),
      .FLAG_BIT  (FLAG_BIT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .ovr     (ovr_s),
      .rd_done (rd_done),
      .cfg_val (cfg_val)
   );

   adc_cfg_sdo #(
      .W (DATA_W)
   ) u_sdo (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_act (frame_act),
      .load      (rd_accept),
      .load_val  (cfg_val),
      .sck_fall  (sck_fall),
      .reading   (reading),
      .chain_en  (chain_mode_i),
      .dout      (spi_dout_o),
      .dout_en   (spi_dout_en_o)
   );

   assign status_en_o  = cfg_val[FIELD_STAT];
   assign span_cmp_o   = cfg_val[FIELD_SPAN];
   assign hiz_mode_o   = cfg_val[FIELD_HIZ];
   assign turbo_o      = cfg_val[FIELD_TURBO];
   assign ovr_flag_n_o = cfg_val[FLAG_BIT];

endmodule

// File: rtl/adc_cfg_port_chk.sv
module adc_cfg_port_chk
   import adc_cfg_pkg::*;
#(
   parameter int                STAGES   = 2,
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] RSV_MASK = 8'hE0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n_i,
   input logic              chain_mode_i,
   input logic              spi_dout_o,
   input logic              spi_dout_en_o,
   input logic              ovr_flag_n_o,
   input logic [3:0]        fields,
   input logic              frame_act,
   input logic              ovr_s,
   input frame_st_t         st,
   input logic              wr_stb,
   input logic              rd_accept,
   input logic              rd_done,
   input logic [DATA_W-1:0] load_val
);

   // Cycles for which the raw frame select has been seen high
   logic [3:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  hi_cnt <= '0;
      else if (!frame_n_i)         hi_cnt <= '0;
      else if (hi_cnt != 4'hF)     hi_cnt <= hi_cnt + 1'b1;
   end

   // R8: between frames the output enable follows the chain strap, data parked low
   assert_idle_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt > 4'(STAGES)) |-> ((spi_dout_en_o == chain_mode_i) && (!spi_dout_en_o || !spi_dout_o)));

   // R7: pad released while hunting or collecting a header inside a frame
   assert_hiz_header_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_act && (st == ST_HUNT || st == ST_HDR)) |-> !spi_dout_en_o);

   // R10: overvoltage forces the alarm low on the next cycle
   assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_s |=> !ovr_flag_n_o);

   // R11: the alarm rises only right after a completed read
   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag_n_o) |-> $past(rd_done));

   // R5: field outputs move only after a completed write frame
   assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fields) |-> $past(wr_stb));

   // R9: no read is accepted while chained
   assert_no_chain_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_accept |-> !$past(chain_mode_i));

   // R6: the byte loaded for readout carries ones in the reserved bits
   assert_rsv_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_accept |-> ((load_val & RSV_MASK) == RSV_MASK));

endmodule

bind adc_cfg_port adc_cfg_port_chk #(
   .STAGES   (SYNC_STAGES),
   .DATA_W   (DATA_W),
   .RSV_MASK (RSV_MASK)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frame_n_i     (frame_n_i),
   .chain_mode_i  (chain_mode_i),
   .spi_dout_o    (spi_dout_o),
   .spi_dout_en_o (spi_dout_en_o),
   .ovr_flag_n_o  (ovr_flag_n_o),
   .fields        ({status_en_o, span_cmp_o, hiz_mode_o, turbo_o}),
   .frame_act     (frame_act),
   .ovr_s         (ovr_s),
   .st            (st),
   .wr_stb        (wr_stb),
   .rd_accept     (rd_accept),
   .rd_done       (rd_done),
   .load_val      (cfg_val)
);

// File: tb/adc_cfg_port_test.sv
module adc_cfg_port_test;

   localparam int         HALF   = 5;
   localparam int         LIMIT  = 190000;
   localparam logic [7:0] HDR_WR = 8'h14;
   localparam logic [7:0] HDR_RD = 8'h54;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0;
   logic frame_n = 1'b1;
   logic din = 1'b1;
   logic chain = 1'b0;
   logic ovr = 1'b0;
   logic dout, dout_en, stat_en, span, hiz, turbo, flag_n;

   always #4 clk = ~clk;

   adc_cfg_port uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .spi_clk_i     (sck),
      .frame_n_i     (frame_n),
      .spi_din_i     (din),
      .chain_mode_i  (chain),
      .overvolt_i    (ovr),
      .spi_dout_o    (dout),
      .spi_dout_en_o (dout_en),
      .status_en_o   (stat_en),
      .span_cmp_o    (span),
      .hiz_mode_o    (hiz),
      .turbo_o       (turbo),
      .ovr_flag_n_o  (flag_n)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [7:0] rd_byte;
   logic       hdr_en_any, dat_en_any, dat_en_all;

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic one_bit(input logic b, input bit is_data, input int idx);
      sck = 1'b0;
      din = b;
      repeat (HALF) @(negedge clk);
      if (is_data) begin
         rd_byte[7-idx] = dout;
         dat_en_any     = dat_en_any | dout_en;
         dat_en_all     = dat_en_all & dout_en;
      end else begin
         hdr_en_any = hdr_en_any | dout_en;
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic xfer(input int pre, input logic [15:0] w, input int nbits);
      hdr_en_any = 1'b0;
      dat_en_any = 1'b0;
      dat_en_all = 1'b1;
      rd_byte    = '0;
      @(negedge clk);
      frame_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < pre; i++) one_bit(1'b1, 1'b0, 0);
      for (int i = 0; i < nbits; i++) one_bit(w[15-i], i >= 8, i - 8);
      frame_n = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
      din = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [4:0] outs();
      return {stat_en, span, hiz, turbo, flag_n};
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (LIMIT) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", LIMIT);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset value, R8 pad released between frames when not chained
      check_eq("R1 reset fields and alarm", outs(), 5'b0000_1);
      check_eq("R8 idle enable unchained", dout_en, 1'b0);

      // R6 read of the reset value; R7 header phase with stray ones
      xfer(3, {HDR_RD, 8'h00}, 16);
      check_eq("R6 read reset byte", rd_byte, 8'hE1);
      check_eq("R6 enable through data", dat_en_all, 1'b1);
      check_eq("R7 no drive during header", hdr_en_any, 1'b0);

      // R2/R4/R6 sweep over all data bytes with varying stray ones
      for (int v = 0; v < 256; v++) begin
         xfer(v % 4, {HDR_WR, 8'(v)}, 16);
         check_eq("R2/R4 write fields", outs(), {v[4:1], 1'b1});
         xfer(0, {HDR_RD, 8'h00}, 16);
         check_eq("R6 readback", rd_byte, {3'b111, v[4:1], 1'b1});
      end

      // R3 corrupted headers
      xfer(0, {8'h16, 8'h00}, 16);
      check_eq("R3 bad write code ignored", outs(), 5'b1111_1);
      xfer(0, {8'h56, 8'h00}, 16);
      check_eq("R3 bad read code no output", dat_en_any, 1'b0);

      // R5 frame cut after four data bits
      xfer(0, {HDR_WR, 8'h00}, 12);
      check_eq("R5 aborted write", outs(), 5'b1111_1);

      xfer(0, {HDR_WR, 8'h00}, 16);
      check_eq("R4 clear fields", outs(), 5'b0000_1);

      // R10 alarm raise
      ovr = 1'b1;
      repeat (6) @(negedge clk);
      check_eq("R10 alarm set", flag_n, 1'b0);

      // R11 read while still active
      xfer(0, {HDR_RD, 8'h00}, 16);
      check_eq("R11 read shows alarm", rd_byte, 8'hE0);
      check_eq("R11 no clear while active", flag_n, 1'b0);
      ovr = 1'b0;
      repeat (6) @(negedge clk);
      check_eq("R11 sticky after release", flag_n, 1'b0);

      // R4 writing bit 0 cannot clear the alarm
      xfer(0, {HDR_WR, 8'h01}, 16);
      check_eq("R4 bit0 write ignored", outs(), 5'b0000_0);

      // R8/R9 chained mode
      chain = 1'b1;
      repeat (2) @(negedge clk);
      check_eq("R8 chained idle enable", dout_en, 1'b1);
      check_eq("R8 chained idle level", dout, 1'b0);
      xfer(0, {HDR_RD, 8'h00}, 16);
      check_eq("R9 chained read no drive", dat_en_any, 1'b0);
      check_eq("R9 chained read keeps alarm", flag_n, 1'b0);
      xfer(0, {HDR_WR, 8'h04}, 16);
      check_eq("R4 write in chained mode", outs(), 5'b0010_0);
      chain = 1'b0;
      repeat (2) @(negedge clk);
      check_eq("R8 unchained idle enable", dout_en, 1'b0);

      // R11 clearing read
      xfer(0, {HDR_RD, 8'h00}, 16);
      check_eq("R11 read returns alarm snapshot", rd_byte, 8'hE4);
      check_eq("R11 alarm cleared after read", flag_n, 1'b1);
      xfer(0, {HDR_RD, 8'h00}, 16);
      check_eq("R11 next read shows clear", rd_byte, 8'hE5);

      finish_run();
   end

endmodule